// File: doc/BRIEF.md
# Pipeline Valid-Bit Cancellation Tracker

This block follows every instruction through a four-stage in-order pipeline and keeps, for each stage, a bit saying whether that instruction may still take effect. This bit is separate from the instruction's condition field. An instruction in the last stage whose condition holds and which redirects the program counter flushes the younger instructions behind it. This covers a taken branch and also a jump to the next address, which is used to refill the pipeline. Once an instruction loses its valid bit it never gets it back. Each stage also carries a small task identifier so that several hardware tasks can share the pipeline. A mode input chooses whether a flush hits only the redirecting task or every task.

The first stage has no storage. Its valid output comes straight from the fetch-valid input, gated by the flush decision of the same cycle. Each later stage registers the gated valid bit and task of the stage before it. The register output is gated again by the current flush, so a late cancellation takes effect immediately. The last stage produces the commit strobe and the task of the committing instruction. When the instruction in stage 3 updates an indirect pointer and is cancelled in that cycle, the block raises a rollback request so the pointer unit can restore the earlier value.

Top module: `pvt_tracker`

## Requirements
- R1: While rst_ni is low, stage_vld_o bits 3..1 are 0 and commit_o and rollback_o are 0.
- R2: stage_vld_o[0] equals fetch_vld_i in the same cycle unless a flush in that cycle cancels it. There is no register in this path.
- R3: With no flush, an instruction that is valid in stage k (bit k-1 of stage_vld_o) is valid in stage k+1 on the next cycle. The task it carried from fetch_task_i appears on commit_task_o when it reaches stage 4.
- R4: commit_o is 1 exactly when stage 4 is valid (stage_vld_o[3]) and cond_i is 1.
- R5: A flush happens when commit_o and jump_i are both 1. With task_scope_i = 1, the flush cancels, in the same cycle, every instruction in stages 1 to 3 whose task equals commit_task_o. Other tasks are unaffected.
- R6: With task_scope_i = 0, a flush cancels the instructions in stages 1 to 3 of every task in the same cycle.
- R7: A cancelled instruction stays invalid in every later stage. A stage is valid only if the stage before it was valid on the previous cycle.
- R8: jump_i has no effect when stage 4 is invalid or cond_i is 0. No younger instruction is cancelled in that case.
- R9: rollback_o is 1 exactly when ptr_upd_i is 1, stage 3 held a registered valid instruction, and a flush cancels it in that cycle.
- R10: Suppose a single task fetches every cycle and then flushes. stage_vld_o[3] is 0 for exactly three cycles after the flushing cycle, and is 1 again on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_vld_i | input | 1 | An instruction enters stage 1 this cycle |
| fetch_task_i | input | 2 | Task of the entering instruction |
| cond_i | input | 1 | Condition of the stage-4 instruction is true |
| jump_i | input | 1 | Stage-4 instruction redirects the program counter |
| task_scope_i | input | 1 | 1: flush only the redirecting task; 0: flush all tasks |
| ptr_upd_i | input | 1 | Stage-3 instruction updates an indirect pointer |
| stage_vld_o | output | 4 | Valid per stage, bit 0 = stage 1 |
| commit_o | output | 1 | Stage-4 instruction takes effect |
| commit_task_o | output | 2 | Task held in stage 4 |
| rollback_o | output | 1 | Restore pointer after a cancelled stage-3 update |

## Verification
The hardest situation to reach is a flush that arrives while the pipeline holds a mix of tasks, some of them already cancelled. The same flush must then clear some stages, leave others alone, and decide whether a pointer update in stage 3 is rolled back. The stimulus table interleaves tasks 0, 1 and 2 on the fetch port. It lines up a scoped flush that must spare the older task and a global flush that must clear everything. It also places a flush against a bubble left by an earlier flush. A directed refill run then counts the bubbles that reach stage 4.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
  parameter int unsigned TASK_W = 2;
  typedef logic [TASK_W-1:0] task_id_t;
endpackage

// File: rtl/pvt_kill_unit.sv
module pvt_kill_unit
  import pvt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  localparam int unsigned NK = NUM_STAGES - 1
) (
  input  logic           flush_i,
  input  logic           scope_i,
  input  task_id_t       br_task_i,
  input  task_id_t       task_i [NK],
  output logic [NK-1:0]  kill_o
);
  for (genvar k = 0; k < NK; k++) begin : g_kill
    assign kill_o[k] = flush_i & (~scope_i | (task_i[k] == br_task_i));
  end
endmodule

// File: rtl/pvt_stage.sv
module pvt_stage
  import pvt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vld_i,
  input  task_id_t task_i,
  input  logic     kill_i,
  input  logic     ptr_i,
  output logic     vld_o,
  output task_id_t task_o,
  output logic     roll_o
);
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      task_o <= '0;
    end else begin
      vld_q  <= vld_i;
      task_o <= task_i;
    end
  end

  // late cancel acts on the flop output
  assign vld_o  = vld_q & ~kill_i;
  assign roll_o = ptr_i & vld_q & kill_i;
endmodule

// File: rtl/pvt_tracker.sv
module pvt_tracker
  import pvt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  localparam int unsigned LAST = NUM_STAGES - 1,
  localparam int unsigned PTR_STAGE = NUM_STAGES - 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fetch_vld_i,
  input  logic [TASK_W-1:0]     fetch_task_i,
  input  logic                  cond_i,
  input  logic                  jump_i,
  input  logic                  task_scope_i,
  input  logic                  ptr_upd_i,
  output logic [NUM_STAGES-1:0] stage_vld_o,
  output logic                  commit_o,
  output logic [TASK_W-1:0]     commit_task_o,
  output logic                  rollback_o
);
  task_id_t        st_task [NUM_STAGES];
  task_id_t        kill_task [LAST];
  logic [LAST-1:0] kill;
  logic [LAST:0]   roll;
  logic            flush;

  assign st_task[0] = fetch_task_i;

  for (genvar k = 0; k < LAST; k++) begin : g_ktask
    assign kill_task[k] = st_task[k];
  end

  assign commit_o      = stage_vld_o[LAST] & cond_i;
  assign flush         = commit_o & jump_i;
  assign commit_task_o = st_task[LAST];

  pvt_kill_unit #(.NUM_STAGES(NUM_STAGES)) u_kill (
    .flush_i   (flush),
    .scope_i   (task_scope_i),
    .br_task_i (st_task[LAST]),
    .task_i    (kill_task),
    .kill_o    (kill)
  );

  // stage 1: no flop
  assign stage_vld_o[0] = fetch_vld_i & ~kill[0];
  assign roll[0]        = 1'b0;

  for (genvar s = 1; s < NUM_STAGES; s++) begin : g_stage
    logic kill_s, ptr_s;
    if (s == LAST) begin : g_last
      assign kill_s = 1'b0;
    end else begin : g_mid
      assign kill_s = kill[s];
    end
    if (s == PTR_STAGE) begin : g_ptr
      assign ptr_s = ptr_upd_i;
    end else begin : g_noptr
      assign ptr_s = 1'b0;
    end
    pvt_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (stage_vld_o[s-1]),
      .task_i (st_task[s-1]),
      .kill_i (kill_s),
      .ptr_i  (ptr_s),
      .vld_o  (stage_vld_o[s]),
      .task_o (st_task[s]),
      .roll_o (roll[s])
    );
  end

  assign rollback_o = |roll;
endmodule

// File: rtl/pvt_checker.sv
module pvt_checker
  import pvt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cond_i,
  input logic                  jump_i,
  input logic                  task_scope_i,
  input logic                  ptr_upd_i,
  input logic [NUM_STAGES-1:0] stage_vld_o,
  input logic                  commit_o,
  input logic                  rollback_o
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  AST_COMMIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (stage_vld_o[LAST] && cond_i)); // R4

  AST_COND_FALSE_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_i || !stage_vld_o[LAST]) |-> !commit_o); // R8

  AST_GLOBAL_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && jump_i && !task_scope_i) |-> (stage_vld_o[LAST-1:0] == '0)); // R6

  AST_ROLLBACK_NEEDS_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_o |-> (commit_o && jump_i && ptr_upd_i)); // R9

  for (genvar s = 0; s < LAST; s++) begin : g_seq
    AST_STICKY_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stage_vld_o[s] |=> !stage_vld_o[s+1]); // R7
    if (s + 1 < LAST) begin : g_adv
      AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage_vld_o[s] && !(commit_o && jump_i)) |=>
          (stage_vld_o[s+1] || (commit_o && jump_i))); // R3
    end else begin : g_adv_last
      AST_ADVANCE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage_vld_o[s] && !(commit_o && jump_i)) |=> stage_vld_o[s+1]); // R3
    end
  end
endmodule

bind pvt_tracker pvt_checker #(.NUM_STAGES(NUM_STAGES)) u_pvt_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cond_i       (cond_i),
  .jump_i       (jump_i),
  .task_scope_i (task_scope_i),
  .ptr_upd_i    (ptr_upd_i),
  .stage_vld_o  (stage_vld_o),
  .commit_o     (commit_o),
  .rollback_o   (rollback_o)
);

// File: tb/tb_pvt_tracker.sv
module tb_pvt_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fetch_vld_i = 1'b0;
  logic [1:0] fetch_task_i = '0;
  logic       cond_i = 1'b0;
  logic       jump_i = 1'b0;
  logic       task_scope_i = 1'b1;
  logic       ptr_upd_i = 1'b0;
  logic [3:0] stage_vld_o;
  logic       commit_o;
  logic [1:0] commit_task_o;
  logic       rollback_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pvt_tracker dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_vld_i   (fetch_vld_i),
    .fetch_task_i  (fetch_task_i),
    .cond_i        (cond_i),
    .jump_i        (jump_i),
    .task_scope_i  (task_scope_i),
    .ptr_upd_i     (ptr_upd_i),
    .stage_vld_o   (stage_vld_o),
    .commit_o      (commit_o),
    .commit_task_o (commit_task_o),
    .rollback_o    (rollback_o)
  );

  // {fv, ftask[1:0], cond, jump, scope, ptr, exp_vld[3:0], exp_commit, exp_ctask[1:0], exp_roll}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    15'b1_00_0_0_1_0_0001_0_00_0, // fill, R2
    15'b1_01_0_0_1_0_0011_0_00_0, // R3
    15'b1_00_0_0_1_0_0111_0_00_0, // R3
    15'b1_01_1_0_1_0_1111_1_00_0, // R4 commit, no jump
    15'b1_00_1_1_1_1_1101_1_01_0, // R5 scoped: task1 killed, task0 spared, no roll
    15'b1_00_0_1_1_0_1011_0_00_0, // R8 cond false, jump ignored
    15'b1_00_1_1_1_0_0111_0_01_0, // R8 stage4 bubble, jump ignored
    15'b1_01_1_1_0_1_1000_1_00_1, // R6 global flush + R9 roll
    15'b1_00_1_0_1_1_0001_0_00_0, // R7 bubbles stay, no roll on bubble
    15'b1_00_0_0_1_0_0011_0_00_0, // R7
    15'b0_00_1_0_1_0_0110_0_01_0, // R2 no fetch
    15'b1_10_1_1_1_1_1001_1_00_1, // R5 + R9 scoped roll, task2 spared
    15'b0_00_0_0_1_0_0010_0_00_0  // R7 killed s3 leaves s4 empty
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int bubbles;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    #2;
    check("R1 stage valid", int'(stage_vld_o), 0);
    check("R1 commit", int'(commit_o), 0);
    check("R1 rollback", int'(rollback_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      fetch_vld_i  = VEC[i][14];
      fetch_task_i = VEC[i][13:12];
      cond_i       = VEC[i][11];
      jump_i       = VEC[i][10];
      task_scope_i = VEC[i][9];
      ptr_upd_i    = VEC[i][8];
      #2;
      check("R2 stage1 valid", int'(stage_vld_o[0]), int'(VEC[i][4]));
      check("R5 R6 R7 R8 stage valid", int'(stage_vld_o[3:1]), int'(VEC[i][7:5]));
      check("R4 commit", int'(commit_o), int'(VEC[i][3]));
      check("R3 commit task", int'(commit_task_o), int'(VEC[i][2:1]));
      check("R9 rollback", int'(rollback_o), int'(VEC[i][0]));
      @(negedge clk_i);
    end

    // R1 asynchronous reset mid-run
    fetch_vld_i = 1'b1; fetch_task_i = 2'd0; cond_i = 1'b1; jump_i = 1'b0; ptr_upd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1 async clear", int'(stage_vld_o[3:1]), 0);
    check("R1 commit clear", int'(commit_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 refill penalty after self-jump
    task_scope_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #2;
    check("R10 stage4 full", int'(stage_vld_o[3]), 1);
    jump_i = 1'b1;
    #1;
    check("R10 flush commit", int'(commit_o), 1);
    @(negedge clk_i);
    jump_i = 1'b0;
    bubbles = 0;
    for (int c = 0; c < 10; c++) begin
      #2;
      if (stage_vld_o[3]) break;
      bubbles++;
      @(negedge clk_i);
    end
    check("R10 bubble count", bubbles, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule